// File: doc/BRIEF.md
# Dual-Memory DSP Address Generator

This block sits beside a processor pipeline and makes two small operand memories, X and Y, behave like an extended register file. Each memory owns four address pointers. Each pointer owns two modifier registers. An access names a memory, a pointer and which of that pointer's two modifiers to apply. The pointer's current value addresses the memory, and the pointer is then post-updated by a linear, modulo or bit-reversed step.

In one cycle the block serves two operand reads and one result write. It therefore applies up to three pointer updates in that cycle, with no stall. Pointers, modifiers and the bank selection are loaded through a register-write port. An optional second X/Y bank pair is built when `DUAL_BANK` is set. Only the selected pair is visible to the operand ports.

Top module: `dual_agu`

## Requirements
- R1: After reset every pointer is 0, every modifier is 0 (step 0, linear) and bank pair 0 is active.
- R2: Read ports 0 and 1 each return, in the same cycle and without a clock edge, the active bank's word at the current value of the pointer they select. Both ports may address X and Y, or the same memory, at once.
- R3: Register port encoding: `cfg_kind` 0 loads pointer `cfg_idx[1:0]` of memory `cfg_idx[2]` (0 = X, 1 = Y) from `cfg_wdata[ADDR_W-1:0]`. Kind 1 loads modifier `cfg_idx[0]` of pointer `cfg_idx[2:1]` of memory `cfg_idx[3]`. Kind 2 loads the bank select from `cfg_wdata[0]`. Kind 3 does nothing. A pointer load wins over an update of that pointer in the same cycle.
- R4: Updates are post-increment. An access uses the current pointer, and the new value is seen from the next cycle on. A pointer that no operand touches keeps its value.
- R5: Modifier word layout: signed step in bits `[ADDR_W-1:0]`, mode in `[ADDR_W+1:ADDR_W]`, length in `[2*ADDR_W+1:ADDR_W+2]`. Mode 0 (and 3) is linear: pointer plus step, wrapping modulo 2^ADDR_W.
- R6: Mode 1 is modulo with length L. The window is the pointer aligned down to the smallest power of two holding L entries. The offset plus step is reduced by L when it reaches L, or raised by L when it goes negative. It is then kept inside the window. L = 0 acts as linear.
- R7: Mode 2 is bit-reversed: the step is added with the carry running from the top address bit downwards. A step of 2^(ADDR_W-1) walks 0, 32, 16, 48, 8, 40, 24, 56 for ADDR_W = 6.
- R8: `*_msel` chooses, per access, which of the pointer's two modifiers drives the update.
- R9: The write port stores `wr_data` into the active bank at its pointer's current value, and post-updates that pointer. A read of the same word in that cycle returns the old data.
- R10: Two reads and one write naming three different pointers update all three in the same cycle.
- R11: When operands in one cycle name the same pointer, only one update is applied. The write operand's modifier wins, then read port 0's, then read port 1's.
- R12: A bank-select write changes the active pair from the next cycle on. The accesses of the cycle of the write still use the old pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register-port write strobe |
| cfg_kind | input | 2 | Register class: pointer, modifier, bank |
| cfg_idx | input | 4 | Register index within the class |
| cfg_wdata | input | 2*ADDR_W+2 | Register write value |
| rd0_en | input | 1 | Read port 0 active (updates its pointer) |
| rd0_y | input | 1 | Read port 0 memory: 0 = X, 1 = Y |
| rd0_ptr | input | 2 | Read port 0 pointer number |
| rd0_msel | input | 1 | Read port 0 modifier choice |
| rd0_data | output | DATA_W | Read port 0 data |
| rd1_en | input | 1 | Read port 1 active |
| rd1_y | input | 1 | Read port 1 memory |
| rd1_ptr | input | 2 | Read port 1 pointer number |
| rd1_msel | input | 1 | Read port 1 modifier choice |
| rd1_data | output | DATA_W | Read port 1 data |
| wr_en | input | 1 | Result write active |
| wr_y | input | 1 | Write memory |
| wr_ptr | input | 2 | Write pointer number |
| wr_msel | input | 1 | Write modifier choice |
| wr_data | input | DATA_W | Result write data |

## Verification
Directed sequences walk the modulo window across its upper and lower wrap with a negative step. They run the eight-point bit-reversed order and pit a pointer load against an update of the same pointer. They stack all three operands on one pointer, and switch banks while a read is in flight. A design that wraps to address 0 instead of the window base, lets the carry ripple upward, applies a read's modifier over the write's, or switches banks a cycle early returns words from the wrong addresses. A long random run then mixes every mode, collision and register write against a bench model of pointers, modifiers and memory contents.

// File: rtl/dual_agu.sv
module dual_agu #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter bit DUAL_BANK = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_kind,
  input  logic [3:0]          cfg_idx,
  input  logic [2*ADDR_W+1:0] cfg_wdata,
  input  logic                rd0_en,
  input  logic                rd0_y,
  input  logic [1:0]          rd0_ptr,
  input  logic                rd0_msel,
  output logic [DATA_W-1:0]   rd0_data,
  input  logic                rd1_en,
  input  logic                rd1_y,
  input  logic [1:0]          rd1_ptr,
  input  logic                rd1_msel,
  output logic [DATA_W-1:0]   rd1_data,
  input  logic                wr_en,
  input  logic                wr_y,
  input  logic [1:0]          wr_ptr,
  input  logic                wr_msel,
  input  logic [DATA_W-1:0]   wr_data
);
  localparam int MW    = 2*ADDR_W + 2;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NB    = DUAL_BANK ? 2 : 1;
  localparam int IW    = ADDR_W + 2;

  logic [ADDR_W-1:0] ptr_q [2][4];
  logic [MW-1:0]     mod_q [2][4][2];
  logic              bank_q;
  logic [DATA_W-1:0] mem_q [NB*2*DEPTH];
  logic              upd_en  [2][4];
  logic              upd_sel [2][4];
  logic [IW-1:0]     ra0, ra1, wa;

  function automatic logic [ADDR_W-1:0] rev(input logic [ADDR_W-1:0] v);
    for (int i = 0; i < ADDR_W; i++) rev[i] = v[ADDR_W-1-i];
  endfunction

  function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p,
                                                 input logic [MW-1:0] m);
    logic [ADDR_W-1:0]        st, len, msk;
    logic signed [ADDR_W+1:0] n, l2;
    st  = m[ADDR_W-1:0];
    len = m[MW-1:ADDR_W+2];
    msk = len - ADDR_W'(1);
    for (int i = 1; i < ADDR_W; i++) msk = msk | (msk >> i);
    l2 = signed'({2'b00, len});
    n  = signed'({2'b00, p & msk}) + signed'({{2{st[ADDR_W-1]}}, st});
    if (n >= l2)          n = n - l2;
    else if (n[ADDR_W+1]) n = n + l2;
    case (m[ADDR_W+1:ADDR_W])
      2'd1:    step_ptr = (p & ~msk) | (n[ADDR_W-1:0] & msk);
      2'd2:    step_ptr = rev(rev(p) + rev(st));
      default: step_ptr = p + st;
    endcase
  endfunction

  // lowest priority first so the write operand lands last
  always_comb begin
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 4; p++) begin
        upd_en[m][p]  = 1'b0;
        upd_sel[m][p] = 1'b0;
        if (rd1_en && rd1_y == 1'(m) && rd1_ptr == 2'(p)) begin
          upd_en[m][p] = 1'b1; upd_sel[m][p] = rd1_msel;
        end
        if (rd0_en && rd0_y == 1'(m) && rd0_ptr == 2'(p)) begin
          upd_en[m][p] = 1'b1; upd_sel[m][p] = rd0_msel;
        end
        if (wr_en && wr_y == 1'(m) && wr_ptr == 2'(p)) begin
          upd_en[m][p] = 1'b1; upd_sel[m][p] = wr_msel;
        end
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < 2; m++)
        for (int p = 0; p < 4; p++) begin
          ptr_q[m][p]    <= '0;
          mod_q[m][p][0] <= '0;
          mod_q[m][p][1] <= '0;
        end
      bank_q <= 1'b0;
    end else begin
      for (int m = 0; m < 2; m++)
        for (int p = 0; p < 4; p++)
          if (cfg_we && cfg_kind == 2'd0 && cfg_idx[2] == 1'(m) && cfg_idx[1:0] == 2'(p))
            ptr_q[m][p] <= cfg_wdata[ADDR_W-1:0];
          else if (upd_en[m][p])
            ptr_q[m][p] <= step_ptr(ptr_q[m][p], mod_q[m][p][upd_sel[m][p]]);
      if (cfg_we && cfg_kind == 2'd1)
        mod_q[cfg_idx[3]][cfg_idx[2:1]][cfg_idx[0]] <= cfg_wdata;
      if (cfg_we && cfg_kind == 2'd2)
        bank_q <= DUAL_BANK & cfg_wdata[0];
    end
  end

  assign ra0 = {bank_q, rd0_y, ptr_q[rd0_y][rd0_ptr]};
  assign ra1 = {bank_q, rd1_y, ptr_q[rd1_y][rd1_ptr]};
  assign wa  = {bank_q, wr_y, ptr_q[wr_y][wr_ptr]};

  always_ff @(posedge clk)
    if (wr_en) mem_q[wa] <= wr_data;

  assign rd0_data = mem_q[ra0];
  assign rd1_data = mem_q[ra1];

  AST_PTR_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_kind == 2'd0 |=>
      ptr_q[$past(cfg_idx[2])][$past(cfg_idx[1:0])] == $past(cfg_wdata[ADDR_W-1:0])); // R3

  AST_X0_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd0_en && !rd0_y && rd0_ptr == 2'd0) && !(rd1_en && !rd1_y && rd1_ptr == 2'd0) &&
    !(wr_en && !wr_y && wr_ptr == 2'd0) && !(cfg_we && cfg_kind == 2'd0 && cfg_idx[2:0] == 3'd0)
      |=> $stable(ptr_q[0][0])); // R4

  AST_SAME_PTR_SAME_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_y == rd1_y && rd0_ptr == rd1_ptr |-> rd0_data == rd1_data); // R2

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wa)] == $past(wr_data)); // R9

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_kind == 2'd2) |=> $stable(bank_q)); // R12
endmodule

// File: tb/dual_agu_tb.sv
`timescale 1ns/1ps
module dual_agu_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we; logic [1:0] cfg_kind; logic [3:0] cfg_idx; logic [13:0] cfg_wdata;
  logic rd0_en, rd0_y, rd0_msel; logic [1:0] rd0_ptr; logic [15:0] rd0_data;
  logic rd1_en, rd1_y, rd1_msel; logic [1:0] rd1_ptr; logic [15:0] rd1_data;
  logic wr_en, wr_y, wr_msel; logic [1:0] wr_ptr; logic [15:0] wr_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  int ptr_m [2][4];
  int mod_m [2][4][2];
  int bank_m;
  int mem_m [2][2][64];

  always #5 clk = ~clk;

  dual_agu u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .rd0_en(rd0_en), .rd0_y(rd0_y), .rd0_ptr(rd0_ptr), .rd0_msel(rd0_msel), .rd0_data(rd0_data),
    .rd1_en(rd1_en), .rd1_y(rd1_y), .rd1_ptr(rd1_ptr), .rd1_msel(rd1_msel), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_y(wr_y), .wr_ptr(wr_ptr), .wr_msel(wr_msel), .wr_data(wr_data));

  function automatic int md(int step, int mode, int len);
    return ((step & 63) | (mode << 6) | (len << 8)) & 16383;
  endfunction

  function automatic int rev6(int v);
    int r = 0;
    for (int i = 0; i < 6; i++) if (((v >> i) & 1) != 0) r = r | (1 << (5 - i));
    return r;
  endfunction

  function automatic int nxt(int p, int mw);
    int step = mw & 63, mode = (mw >> 6) & 3, len = (mw >> 8) & 63, msk, n;
    if (step >= 32) step = step - 64;
    if (mode == 1) begin
      if (len == 0) msk = 63;
      else begin msk = 0; while (msk < len - 1) msk = msk * 2 + 1; end
      n = (p & msk) + step;
      if (n >= len) n = n - len;
      else if (n < 0) n = n + len;
      return (p & ~msk & 63) | (n & msk);
    end
    if (mode == 2) return rev6((rev6(p) + rev6(step & 63)) & 63);
    return (p + step) & 63;
  endfunction

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    cfg_we = 0; cfg_kind = 0; cfg_idx = 0; cfg_wdata = 0;
    rd0_en = 0; rd0_y = 0; rd0_ptr = 0; rd0_msel = 0;
    rd1_en = 0; rd1_y = 0; rd1_ptr = 0; rd1_msel = 0;
    wr_en = 0; wr_y = 0; wr_ptr = 0; wr_msel = 0; wr_data = 0;
  endtask

  task automatic model_reset();
    foreach (ptr_m[m, p]) begin ptr_m[m][p] = 0; mod_m[m][p][0] = 0; mod_m[m][p][1] = 0; end
    bank_m = 0;
  endtask

  task automatic model_edge();
    int np [2][4];
    np = ptr_m;
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 4; p++) begin
        int sel = -1;
        if (rd1_en && int'(rd1_y) == m && int'(rd1_ptr) == p) sel = int'(rd1_msel);
        if (rd0_en && int'(rd0_y) == m && int'(rd0_ptr) == p) sel = int'(rd0_msel);
        if (wr_en && int'(wr_y) == m && int'(wr_ptr) == p) sel = int'(wr_msel);
        if (sel >= 0) np[m][p] = nxt(ptr_m[m][p], mod_m[m][p][sel]);
      end
    if (wr_en) mem_m[bank_m][wr_y][ptr_m[wr_y][wr_ptr]] = int'(wr_data);
    if (cfg_we) begin
      if (cfg_kind == 2'd0) np[cfg_idx[2]][cfg_idx[1:0]] = int'(cfg_wdata) & 63;
      if (cfg_kind == 2'd1) mod_m[cfg_idx[3]][cfg_idx[2:1]][cfg_idx[0]] = int'(cfg_wdata);
      if (cfg_kind == 2'd2) bank_m = int'(cfg_wdata[0]);
    end
    ptr_m = np;
  endtask

  // called just after a falling edge with inputs set; e0/e1 are explicit expected addresses
  task automatic tick(input string tag, input int e0, input int e1);
    #1;
    if (rd0_en) chk(int'(rd0_data), mem_m[bank_m][rd0_y][ptr_m[rd0_y][rd0_ptr]], tag);
    if (rd0_en && e0 >= 0) chk(int'(rd0_data), mem_m[bank_m][rd0_y][e0], tag);
    if (rd1_en) chk(int'(rd1_data), mem_m[bank_m][rd1_y][ptr_m[rd1_y][rd1_ptr]], tag);
    if (rd1_en && e1 >= 0) chk(int'(rd1_data), mem_m[bank_m][rd1_y][e1], tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    idle();
  endtask

  task automatic op0(input int y, input int p, input int s);
    rd0_en = 1; rd0_y = 1'(y); rd0_ptr = 2'(p); rd0_msel = 1'(s);
  endtask
  task automatic op1(input int y, input int p, input int s);
    rd1_en = 1; rd1_y = 1'(y); rd1_ptr = 2'(p); rd1_msel = 1'(s);
  endtask
  task automatic opw(input int y, input int p, input int s);
    wr_en = 1; wr_y = 1'(y); wr_ptr = 2'(p); wr_msel = 1'(s); wr_data = 16'($urandom);
  endtask
  task automatic cfg(input int k, input int idx, input int d);
    cfg_we = 1; cfg_kind = 2'(k); cfg_idx = 4'(idx); cfg_wdata = 14'(d);
  endtask
  task automatic setp(input int y, input int p, input int v);
    cfg(0, y*4 + p, v); tick("R3", -1, -1);
  endtask
  task automatic setm(input int y, input int p, input int k, input int v);
    cfg(1, y*8 + p*2 + k, v); tick("R5", -1, -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-chain got hang exp finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a6 [8] = '{20, 23, 16, 19, 22, 25, 18, 24};
    int a7 [8] = '{0, 32, 16, 48, 8, 40, 24, 56};
    void'($urandom(32'd4242));
    idle(); model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // fill both bank pairs through the write port (R9)
    setm(0, 0, 0, md(1, 0, 0));
    setm(1, 0, 0, md(1, 0, 0));
    for (int b = 0; b < 2; b++) begin
      cfg(2, 0, b); tick("R12", -1, -1);
      for (int y = 0; y < 2; y++)
        for (int i = 0; i < 64; i++) begin opw(y, 0, 0); tick("R9", -1, -1); end
    end
    for (int i = 0; i < 64; i++) begin op0(0, 0, 0); op1(1, 0, 0); tick("R9", i, i); end
    // reset again: memory keeps contents, registers clear (R1)
    rst_n = 0;
    repeat (2) @(negedge clk);
    model_reset(); rst_n = 1;
    for (int p = 0; p < 4; p++) begin op0(0, p, 0); op1(1, p, 1); tick("R1", 0, 0); end
    for (int p = 0; p < 4; p++) begin op0(0, p, 1); op1(1, p, 0); tick("R1", 0, 0); end
    // linear with per-access modifier choice (R5, R8)
    setm(0, 1, 0, md(5, 0, 0)); setm(0, 1, 1, md(-3, 0, 0)); setp(0, 1, 10);
    op0(0, 1, 0); tick("R5", 10, -1);
    op0(0, 1, 0); tick("R5", 15, -1);
    op0(0, 1, 1); tick("R8", 20, -1);
    op0(0, 1, 0); tick("R8", 17, -1);
    // load beats update (R3), post-increment and idle hold (R4)
    op0(0, 1, 0); cfg(0, 1, 40); tick("R3", 22, -1);
    op0(0, 1, 1); tick("R3", 40, -1);
    op0(0, 1, 0); tick("R4", 37, -1);
    tick("R4", -1, -1);
    op0(0, 1, 0); tick("R4", 42, -1);
    op1(0, 1, 0); tick("R4", -1, 47);
    // modulo window, length 10 inside a 16-word window (R6)
    setm(0, 2, 0, md(3, 1, 10)); setm(0, 2, 1, md(-4, 1, 10)); setp(0, 2, 20);
    for (int i = 0; i < 8; i++) begin op0(0, 2, (i == 6) ? 1 : 0); tick("R6", a6[i], -1); end
    // bit-reversed walk (R7)
    setm(1, 3, 0, md(32, 2, 0)); setp(1, 3, 0);
    for (int i = 0; i < 8; i++) begin op1(1, 3, 0); tick("R7", -1, a7[i]); end
    // collisions on one pointer (R11), read-before-write (R9)
    setm(0, 2, 0, md(1, 0, 0)); setm(0, 2, 1, md(2, 0, 0)); setp(0, 2, 0);
    opw(0, 2, 1); op0(0, 2, 0); op1(0, 2, 0); tick("R11", 0, 0);
    op0(0, 2, 1); op1(0, 2, 0); tick("R11", 2, 2);
    op1(0, 2, 0); tick("R11", -1, 4);
    setp(0, 2, 0);
    op0(0, 2, 0); tick("R9", 0, -1);
    // three pointer updates in one cycle (R10)
    setm(0, 0, 0, md(1, 0, 0)); setm(0, 3, 0, md(1, 0, 0)); setm(1, 0, 0, md(1, 0, 0));
    setp(0, 0, 5); setp(0, 3, 9); setp(1, 0, 30);
    op0(0, 0, 0); op1(1, 0, 0); opw(0, 3, 0); tick("R10", 5, 30);
    op0(0, 3, 0); op1(1, 0, 0); tick("R10", 10, 31);
    op0(0, 0, 0); tick("R10", 6, -1);
    setp(0, 3, 9);
    op0(0, 3, 0); tick("R9", 9, -1);
    // bank switch takes effect one cycle later (R12)
    op0(0, 0, 0); cfg(2, 0, 1); tick("R12", 7, -1);
    op0(0, 0, 0); tick("R12", 8, -1);
    op0(0, 0, 0); cfg(2, 0, 0); tick("R12", 9, -1);
    op0(0, 0, 0); tick("R12", 10, -1);
    // random mix (R2 and all modes)
    for (int i = 0; i < 4000; i++) begin
      rd0_en = 1'($urandom); rd0_y = 1'($urandom); rd0_ptr = 2'($urandom); rd0_msel = 1'($urandom);
      rd1_en = 1'($urandom); rd1_y = 1'($urandom); rd1_ptr = 2'($urandom); rd1_msel = 1'($urandom);
      wr_en = 1'($urandom); wr_y = 1'($urandom); wr_ptr = 2'($urandom); wr_msel = 1'($urandom);
      wr_data = 16'($urandom);
      cfg_we = (($urandom % 8) == 0); cfg_kind = 2'($urandom); cfg_idx = 4'($urandom);
      cfg_wdata = 14'($urandom);
      tick("R2", -1, -1);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule